// File: doc/BRIEF.md
# Wake-Up Event Detector

This block sits next to a power-management sequencer that keeps the system in a low-power clock state. It collects the conditions that should bring the system back to full-speed clocking and raises a one-cycle `wake_pulse` when one of them occurs. The conditions are interrupt request lines, DMA request lines, a ring-indicate input and a suspend/resume pin.

A software-visible activity mask selects the sources. Interrupt lines also need an enable from the interrupt controller. The DMA lines that are eligible depend on the bus-mode input. All selected contributions are ORed into one combined signal, and a single rising-edge detector runs on that signal. While a system-management or non-maskable handler is active, a wake edge is held as pending. The pending wake is released as one pulse once the handler finishes.

Ring-indicate events are latched inside the block until the next refresh strobe. A sticky four-bit resume status records which source classes caused wakes. Software clears it by writing ones.

Top module: `wake_detect`

## Requirements
- R1: Wakes come from rising edges of the OR of all enabled contributions. While any enabled contribution stays high, the rise of another gives no wake.
- R2: Interrupt line i (`irq_req[i]`) contributes only when `irq_ctl_en[i]` is 1 and mask bit 3+i is 1.
- R3: DMA line mapping with `lbus_mode`=0: line 1 uses mask bit 0, line 5 uses mask bit 1, and lines 3, 4, 6 and 7 use mask bit 2. With `lbus_mode`=1: line 1 uses bit 0, line 2 uses bit 1 and line 5 uses bit 2. Every other line never wakes. No second-level enable applies to DMA lines.
- R4: No filtering. An enabled line that is high for a single clock cycle produces a wake.
- R5: A rising edge on `ring_in` sets an internal latch that stays set until a `refresh_stb` cycle. The latch contributes when mask bit 6 is 1. Interrupt and DMA lines are not latched.
- R6: `wake_pulse` is never asserted in the cycle after a cycle in which `hdl_active` was high.
- R7: One or more edges during a handler produce exactly one `wake_pulse`, one cycle after `hdl_active` is first sampled low.
- R8: `resume_stat` bit 0 records interrupt, bit 1 DMA, bit 2 ring-indicate and bit 3 suspend/resume. Bits are set when a wake edge occurs with that class contributing, and they stay set until cleared. A write with `stat_clr_we` clears the bits that are 1 in `stat_clr_data`. A bit being set in the same cycle wins over its clear.
- R9: The ring-indicate status bit is set again every cycle while the latch is held. A clear takes effect only on a write made after the refresh that dropped the latch.
- R10: `susp_in` has no mask. Its rising edge wakes the system even with an all-zero mask.
- R11: After reset `wake_pulse` is 0, `resume_stat` is 0 and nothing is pending.
- R12: `wake_pulse` lasts one cycle for a source that stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | IRQ_N | Interrupt request lines |
| irq_ctl_en | input | IRQ_N | Per-line enable from the interrupt controller |
| drq_req | input | DRQ_N | DMA request lines 0..DRQ_N-1 |
| ring_in | input | 1 | Ring-indicate input |
| susp_in | input | 1 | Suspend/resume pin (unmaskable) |
| act_mask | input | IRQ_N+4 | Activity mask, 1 enables a source |
| lbus_mode | input | 1 | 0 selects full-ISA DMA mapping, 1 selects local-bus mapping |
| hdl_active | input | 1 | Temporary-on handler running |
| refresh_stb | input | 1 | Refresh strobe, drops the ring latch |
| stat_clr_we | input | 1 | Status clear write strobe |
| stat_clr_data | input | 4 | Write-one-to-clear status bits |
| wake_pulse | output | 1 | One-cycle return-to-full-speed request |
| resume_stat | output | 4 | Sticky wake-cause status |

## Verification
An interrupt, DMA or suspend input driven after one falling edge shows up on `wake_pulse` and `resume_stat` at the next falling edge, because one register lies between them. A ring-indicate input passes through the latch first, so its wake is due one falling edge later. A pending wake is due at the first falling edge after `hdl_active` is driven low. A status clear is visible one falling edge after its write. The bench drives inputs on falling edges and samples exactly at these due points. It then samples one edge further to confirm that each pulse has ended.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int STAT_W  = 4;
    localparam int CLS_IRQ = 0;
    localparam int CLS_DRQ = 1;
    localparam int CLS_RNG = 2;
    localparam int CLS_SUS = 3;

    typedef struct packed {
        logic ring_prev;
        logic held;
    } ring_state_t;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              pend;
        logic              wake;
        logic              comb;
    } ctrl_state_t;
endpackage

// File: rtl/wk_src_select.sv
module wk_src_select
    import wk_pkg::*;
#(
    parameter int IRQ_N  = 3,
    parameter int DRQ_N  = 8,
    parameter int MASK_W = IRQ_N + 4
) (
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_ctl_en,
    input  logic [DRQ_N-1:0]  drq_req,
    input  logic              ring_held,
    input  logic              susp_in,
    input  logic [MASK_W-1:0] act_mask,
    input  logic              lbus_mode,
    output logic [STAT_W-1:0] cls
);
    localparam int MB_IRQ0 = 3;
    localparam int MB_RING = MB_IRQ0 + IRQ_N;

    // slot 0: not eligible; slot k (1..3): mask bit k-1
    function automatic logic [1:0] drq_slot(input logic lb, input int line);
        logic [1:0] s;
        s = 2'd0;
        if (lb) begin
            if (line == 1) s = 2'd1;
            else if (line == 2) s = 2'd2;
            else if (line == 5) s = 2'd3;
        end else begin
            if (line == 1) s = 2'd1;
            else if (line == 5) s = 2'd2;
            else if (line == 3 || line == 4 || line == 6 || line == 7) s = 2'd3;
        end
        return s;
    endfunction

    logic [IRQ_N-1:0] irq_hit;
    logic [DRQ_N-1:0] drq_hit;

    genvar gi;
    generate
        for (gi = 0; gi < IRQ_N; gi++) begin : g_irq
            assign irq_hit[gi] = irq_req[gi] & irq_ctl_en[gi] & act_mask[MB_IRQ0+gi];
        end
    endgenerate

    always_comb begin
        drq_hit = '0;
        for (int j = 0; j < DRQ_N; j++) begin
            case (drq_slot(lbus_mode, j))
                2'd1:    drq_hit[j] = drq_req[j] & act_mask[0];
                2'd2:    drq_hit[j] = drq_req[j] & act_mask[1];
                2'd3:    drq_hit[j] = drq_req[j] & act_mask[2];
                default: drq_hit[j] = 1'b0;
            endcase
        end
    end

    always_comb begin
        cls          = '0;
        cls[CLS_IRQ] = |irq_hit;
        cls[CLS_DRQ] = |drq_hit;
        cls[CLS_RNG] = ring_held & act_mask[MB_RING];
        cls[CLS_SUS] = susp_in;
    end
endmodule

// File: rtl/wk_ring_latch.sv
module wk_ring_latch
    import wk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring_in,
    input  logic refresh_stb,
    output logic held
);
    ring_state_t st_d, st_q;
    logic        ring_rise;

    always_comb begin
        st_d           = st_q;
        ring_rise      = ring_in & ~st_q.ring_prev;
        st_d.ring_prev = ring_in;
        st_d.held      = (st_q.held & ~refresh_stb) | ring_rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.held;

    AST_RING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !refresh_stb) |=> st_q.held); // R5
    AST_RING_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_stb && !(ring_in && !st_q.ring_prev)) |=> !st_q.held); // R5
endmodule

// File: rtl/wk_edge_ctrl.sv
module wk_edge_ctrl
    import wk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cls,
    input  logic              hdl_active,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_data,
    output logic              wake_pulse,
    output logic [STAT_W-1:0] resume_stat
);
    ctrl_state_t       st_d, st_q;
    logic              comb_src;
    logic              rise;
    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] clr_bits;

    always_comb begin
        st_d      = st_q;
        comb_src  = |cls;
        rise      = comb_src & ~st_q.comb;
        st_d.comb = comb_src;
        st_d.wake = ~hdl_active & (rise | st_q.pend);
        st_d.pend =  hdl_active & (rise | st_q.pend);
        set_bits  = rise ? cls : '0;
        set_bits[CLS_RNG] = set_bits[CLS_RNG] | cls[CLS_RNG];
        clr_bits  = stat_clr_we ? stat_clr_data : '0;
        st_d.stat = (st_q.stat & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_pulse  = st_q.wake;
    assign resume_stat = st_q.stat;

    AST_NO_WAKE_IN_HDL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> !$past(hdl_active)); // R6
    AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !hdl_active) |=> st_q.wake); // R7
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_clr_we) |-> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat))); // R8
    AST_SUSP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cls[CLS_SUS] && !st_q.comb && !hdl_active) |=> st_q.wake); // R10
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wk_pkg::*;
#(
    parameter int IRQ_N = 3,
    parameter int DRQ_N = 8,
    localparam int MASK_W = IRQ_N + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_ctl_en,
    input  logic [DRQ_N-1:0]  drq_req,
    input  logic              ring_in,
    input  logic              susp_in,
    input  logic [MASK_W-1:0] act_mask,
    input  logic              lbus_mode,
    input  logic              hdl_active,
    input  logic              refresh_stb,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_data,
    output logic              wake_pulse,
    output logic [STAT_W-1:0] resume_stat
);
    logic              ring_held;
    logic [STAT_W-1:0] cls;

    wk_ring_latch u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_in     (ring_in),
        .refresh_stb (refresh_stb),
        .held        (ring_held)
    );

    wk_src_select #(
        .IRQ_N  (IRQ_N),
        .DRQ_N  (DRQ_N),
        .MASK_W (MASK_W)
    ) u_sel (
        .irq_req    (irq_req),
        .irq_ctl_en (irq_ctl_en),
        .drq_req    (drq_req),
        .ring_held  (ring_held),
        .susp_in    (susp_in),
        .act_mask   (act_mask),
        .lbus_mode  (lbus_mode),
        .cls        (cls)
    );

    wk_edge_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cls           (cls),
        .hdl_active    (hdl_active),
        .stat_clr_we   (stat_clr_we),
        .stat_clr_data (stat_clr_data),
        .wake_pulse    (wake_pulse),
        .resume_stat   (resume_stat)
    );
endmodule

// File: tb/sim_wake_detect.sv
module sim_wake_detect;
    localparam int IRQ_N = 3;
    localparam int DRQ_N = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IRQ_N-1:0] irq_req = '0;
    logic [IRQ_N-1:0] irq_ctl_en = '0;
    logic [DRQ_N-1:0] drq_req = '0;
    logic             ring_in = 1'b0;
    logic             susp_in = 1'b0;
    logic [IRQ_N+3:0] act_mask = '0;
    logic             lbus_mode = 1'b0;
    logic             hdl_active = 1'b0;
    logic             refresh_stb = 1'b0;
    logic             stat_clr_we = 1'b0;
    logic [3:0]       stat_clr_data = '0;
    logic             wake_pulse;
    logic [3:0]       resume_stat;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wake_detect #(.IRQ_N(IRQ_N), .DRQ_N(DRQ_N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ctl_en(irq_ctl_en),
        .drq_req(drq_req), .ring_in(ring_in), .susp_in(susp_in),
        .act_mask(act_mask), .lbus_mode(lbus_mode), .hdl_active(hdl_active),
        .refresh_stb(refresh_stb), .stat_clr_we(stat_clr_we),
        .stat_clr_data(stat_clr_data), .wake_pulse(wake_pulse),
        .resume_stat(resume_stat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        stat_clr_we = 1'b1;
        stat_clr_data = 4'hF;
        tick();
        stat_clr_we = 1'b0;
        stat_clr_data = 4'h0;
    endtask

    // expected DMA eligibility from R3
    function automatic logic exp_drq(input logic lb, input int line, input logic [2:0] m);
        if (lb) begin
            if (line == 1) return m[0];
            if (line == 2) return m[1];
            if (line == 5) return m[2];
            return 1'b0;
        end
        if (line == 1) return m[0];
        if (line == 5) return m[1];
        if (line == 3 || line == 4 || line == 6 || line == 7) return m[2];
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic e;
        repeat (3) tick();
        chk("R11 wake after reset", wake_pulse, 0);
        chk("R11 status after reset", resume_stat, 0);
        rst_n = 1'b1;
        tick();
        chk("R11 wake idle", wake_pulse, 0);

        // R3 sweep: mode x line x DMA mask bits
        for (int md = 0; md < 2; md++) begin
            for (int ln = 0; ln < DRQ_N; ln++) begin
                for (int m = 0; m < 8; m++) begin
                    lbus_mode = md[0];
                    act_mask = '0;
                    act_mask[2:0] = m[2:0];
                    tick();
                    clear_all();
                    drq_req[ln] = 1'b1;
                    tick();
                    e = exp_drq(md[0], ln, m[2:0]);
                    chk("R3 drq wake", wake_pulse, e);
                    chk("R3 drq status", resume_stat, e ? 4'h2 : 4'h0);
                    drq_req = '0;
                    tick();
                    chk("R12 drq pulse ends", wake_pulse, 0);
                end
            end
        end

        // R2/R4 sweep: one-cycle irq pulses, controller enable x mask bit
        lbus_mode = 1'b0;
        for (int i = 0; i < IRQ_N; i++) begin
            for (int en = 0; en < 2; en++) begin
                for (int mb = 0; mb < 2; mb++) begin
                    act_mask = '0;
                    act_mask[3+i] = mb[0];
                    irq_ctl_en = '0;
                    irq_ctl_en[i] = en[0];
                    tick();
                    clear_all();
                    irq_req[i] = 1'b1;
                    tick();
                    irq_req = '0;
                    chk("R2 R4 irq wake", wake_pulse, en[0] & mb[0]);
                    chk("R2 irq status", resume_stat, (en[0] & mb[0]) ? 4'h1 : 4'h0);
                    tick();
                    chk("R4 irq pulse ends", wake_pulse, 0);
                end
            end
        end

        // R1 / R12: held source blocks other rises; pulse is one cycle
        irq_ctl_en = '1;
        act_mask = '0;
        act_mask[0] = 1'b1;
        act_mask[3] = 1'b1;
        tick();
        clear_all();
        drq_req[1] = 1'b1;
        tick();
        chk("R12 held drq wakes", wake_pulse, 1);
        tick();
        chk("R12 held drq single cycle", wake_pulse, 0);
        irq_req[0] = 1'b1;
        tick();
        chk("R1 blocked irq", wake_pulse, 0);
        chk("R1 blocked irq no status", resume_stat, 4'h2);
        drq_req = '0;
        irq_req = '0;
        tick();
        tick();
        irq_req[0] = 1'b1;
        tick();
        chk("R1 irq after release", wake_pulse, 1);
        irq_req = '0;
        tick();

        // R6 / R7: deferral during handler
        clear_all();
        hdl_active = 1'b1;
        irq_req[0] = 1'b1;
        tick();
        chk("R6 no wake in handler", wake_pulse, 0);
        irq_req[0] = 1'b0;
        tick();
        chk("R6 no wake in handler 2", wake_pulse, 0);
        irq_req[0] = 1'b1;
        tick();
        chk("R6 second edge deferred", wake_pulse, 0);
        chk("R8 status while deferred", resume_stat, 4'h1);
        irq_req[0] = 1'b0;
        hdl_active = 1'b0;
        tick();
        chk("R7 pending released", wake_pulse, 1);
        tick();
        chk("R7 exactly one pulse", wake_pulse, 0);
        tick();
        chk("R7 no extra pulse", wake_pulse, 0);

        // R5 / R9: ring latch and status
        act_mask = '0;
        act_mask[IRQ_N+3] = 1'b1;
        tick();
        clear_all();
        ring_in = 1'b1;
        tick();
        ring_in = 1'b0;
        chk("R5 ring latch delay", wake_pulse, 0);
        tick();
        chk("R5 ring wakes", wake_pulse, 1);
        chk("R5 ring status", resume_stat, 4'h4);
        stat_clr_we = 1'b1;
        stat_clr_data = 4'h4;
        tick();
        stat_clr_we = 1'b0;
        chk("R9 clear before refresh fails", resume_stat, 4'h4);
        refresh_stb = 1'b1;
        tick();
        refresh_stb = 1'b0;
        chk("R9 status after refresh", resume_stat, 4'h4);
        stat_clr_we = 1'b1;
        tick();
        stat_clr_we = 1'b0;
        chk("R9 clear after refresh", resume_stat, 4'h0);
        act_mask[3] = 1'b1;
        irq_req[0] = 1'b1;
        tick();
        chk("R5 latch released unblocks", wake_pulse, 1);
        irq_req = '0;
        tick();

        // R5: masked ring gives no wake
        act_mask = '0;
        clear_all();
        ring_in = 1'b1;
        tick();
        ring_in = 1'b0;
        tick();
        chk("R5 masked ring no wake", wake_pulse, 0);
        tick();
        chk("R5 masked ring no status", resume_stat, 0);
        refresh_stb = 1'b1;
        tick();
        refresh_stb = 1'b0;
        tick();

        // R10: suspend pin with zero mask
        susp_in = 1'b1;
        tick();
        chk("R10 suspend wakes unmasked", wake_pulse, 1);
        chk("R10 suspend status", resume_stat, 4'h8);
        susp_in = 1'b0;
        tick();

        // R8: set wins over same-cycle clear, other bits cleared
        act_mask[3] = 1'b1;
        irq_req[0] = 1'b1;
        tick();
        irq_req[0] = 1'b0;
        chk("R8 two classes sticky", resume_stat, 4'h9);
        tick();
        stat_clr_we = 1'b1;
        stat_clr_data = 4'hF;
        susp_in = 1'b1;
        tick();
        stat_clr_we = 1'b0;
        susp_in = 1'b0;
        chk("R8 set wins over clear", resume_stat, 4'h8);
        tick();
        chk("R8 status holds", resume_stat, 4'h8);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule